// File: doc/BRIEF.md
# Game Port I/O Select Decoder

This block watches a 10-bit I/O address, an address-enable, an active-low upper-address-zero qualifier and the active-low read and write strobes of a host bus. When the host touches the game-port location, it pulls active-low select lines that external game-port logic uses as its chip select or as its read and write strobes. A mode strap is sampled while master reset is held. After reset it decides how the two select pins behave, and it stays fixed until the next reset.

With the strap high, the block runs in combined mode. The first select pin is one enable that falls on any read or write of the port, and the second pin stays high. With the strap low, the block runs in split mode. The first pin becomes a read strobe and the second a write strobe. The outputs are combinational from the bus inputs and do not pass through any register. The latched mode is also brought out on a pin so the rest of the chip can see it.

Top module: `gameport_decode`

## Requirements
- R1: A hit occurs only when address bits 9..0 equal 0x201 (parameter default). Any other address leaves both select outputs high.
- R2: While `bus_aen` is high, both select outputs stay high, whatever the address and strobes are.
- R3: While `io_hi_zero_n` is high, meaning upper address bits 15..10 are not all zero, both select outputs stay high.
- R4: In combined mode (latched strap = 1), `sel_a_n` is low exactly while there is a hit and either `rd_n` or `wr_n` is low. `sel_b_n` stays high.
- R5: In split mode (latched strap = 0), `sel_a_n` is low exactly while there is a hit and `rd_n` is low. `wr_n` has no effect on it.
- R6: In split mode, `sel_b_n` is low exactly while there is a hit and `wr_n` is low. `rd_n` has no effect on it.
- R7: `mode_strap` is sampled on every clock edge while `rst` is high. The value from the last such edge is held while `rst` is low and is shown on `mode_o` (1 = combined, 0 = split). Later strap changes have no effect.
- R8: While `rst` is high, both select outputs are high.
- R9: The select outputs follow the bus inputs without a clock. Releasing a strobe raises the select in the same cycle, before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the strap |
| rst | input | 1 | Master reset, active high |
| mode_strap | input | 1 | Mode strap pin, sampled during reset |
| bus_addr | input | 10 | I/O address bits 9..0 |
| bus_aen | input | 1 | Address enable; high blocks all selects |
| io_hi_zero_n | input | 1 | Low when I/O address bits 15..10 are all zero |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| sel_a_n | output | 1 | Combined enable, or the read strobe in split mode |
| sel_b_n | output | 1 | Write strobe in split mode; high in combined mode |
| mode_o | output | 1 | Latched mode strap |

## Verification
The bench uses the default parameters: a 10-bit address and a target of 0x201. It walks every single-bit neighbour of the target, so a wrong bit in the comparator shows up as a false hit. Both modes are reached by resetting the block with the strap at each level. After that, the strap is toggled while the block is out of reset to show that the mode does not move. Strobes are released between clock edges to confirm that the select lines respond without a register.

// File: rtl/gameport_pkg.sv
package gameport_pkg;
  typedef enum logic {
    MODE_SPLIT    = 1'b0,
    MODE_COMBINED = 1'b1
  } gp_mode_e;
endpackage

// File: rtl/gp_strap_latch.sv
module gp_strap_latch
  import gameport_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strap_i,
  output gp_mode_e mode_q
);
  // Follows the strap while reset is held, then freezes.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= gp_mode_e'(strap_i);
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rst || $stable(mode_q))); // R7
endmodule

// File: rtl/gp_addr_match.sv
module gp_addr_match #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] TARGET = 10'h201
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              hi_zero_n_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] bit_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_eq[i] = (addr_i[i] == TARGET[i]);
  end

  // Full 16-bit decode: low bits compared here, upper bits via qualifier.
  assign hit_o = (&bit_eq) && !aen_i && !hi_zero_n_i;
endmodule

// File: rtl/gp_sel_drive.sv
module gp_sel_drive
  import gameport_pkg::*;
(
  input  logic     rst,
  input  gp_mode_e mode_i,
  input  logic     hit_i,
  input  logic     rd_n,
  input  logic     wr_n,
  output logic     sel_a_n,
  output logic     sel_b_n
);
  always_comb begin
    sel_a_n = 1'b1;
    sel_b_n = 1'b1;
    if (!rst && hit_i) begin
      if (mode_i == MODE_COMBINED) begin
        sel_a_n = rd_n && wr_n;
      end else begin
        sel_a_n = rd_n;
        sel_b_n = wr_n;
      end
    end
  end
endmodule

// File: rtl/gameport_decode.sv
module gameport_decode
  import gameport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] GAME_ADDR = 10'h201
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_aen,
  input  logic              io_hi_zero_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              sel_a_n,
  output logic              sel_b_n,
  output logic              mode_o
);
  gp_mode_e mode_q;
  logic     hit;

  gp_strap_latch u_strap (
    .clk     (clk),
    .rst     (rst),
    .strap_i (mode_strap),
    .mode_q  (mode_q)
  );

  gp_addr_match #(.ADDR_W(ADDR_W), .TARGET(GAME_ADDR)) u_match (
    .addr_i      (bus_addr),
    .aen_i       (bus_aen),
    .hi_zero_n_i (io_hi_zero_n),
    .hit_o       (hit)
  );

  gp_sel_drive u_drive (
    .rst     (rst),
    .mode_i  (mode_q),
    .hit_i   (hit),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n)
  );

  assign mode_o = mode_q;

  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != GAME_ADDR) |-> (sel_a_n && sel_b_n)); // R1
  AST_AEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    bus_aen |-> (sel_a_n && sel_b_n)); // R2
  AST_HI_BLOCK: assert property (@(posedge clk) disable iff (rst)
    io_hi_zero_n |-> (sel_a_n && sel_b_n)); // R3
  AST_COMB_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    mode_o |-> sel_b_n); // R4
  AST_SPLIT_RD: assert property (@(posedge clk) disable iff (rst)
    (!mode_o && !sel_a_n) |-> !rd_n); // R5
  AST_SPLIT_WR: assert property (@(posedge clk) disable iff (rst)
    (!mode_o && !sel_b_n) |-> !wr_n); // R6
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |-> (sel_a_n && sel_b_n)); // R9
endmodule

// File: tb/gameport_decode_test.sv
`timescale 1ns/1ps
module gameport_decode_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_strap = 1'b1;
  logic [9:0] bus_addr = '0;
  logic       bus_aen = 1'b0;
  logic       io_hi_zero_n = 1'b0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       sel_a_n, sel_b_n, mode_o;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  gameport_decode uut (
    .clk(clk), .rst(rst), .mode_strap(mode_strap), .bus_addr(bus_addr),
    .bus_aen(bus_aen), .io_hi_zero_n(io_hi_zero_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive on the falling edge, let combinational paths settle, then sample.
  task automatic bus(input logic [9:0] a, input logic aen, input logic hz,
                     input logic r, input logic w);
    @(negedge clk);
    bus_addr = a; bus_aen = aen; io_hi_zero_n = hz; rd_n = r; wr_n = w;
    #2;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; mode_strap = strap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mode_strap = 1'b1;
    bus_addr = 10'h201; bus_aen = 0; io_hi_zero_n = 0; rd_n = 0; wr_n = 0;
    @(posedge clk); #2;
    check("R8 reset holds selects", {sel_a_n, sel_b_n}, 2'b11);
    rd_n = 1; wr_n = 1;
  endtask

  task automatic t_combined();
    do_reset(1'b1);
    check("R7 mode latched combined", {1'b0, mode_o}, 2'b01);
    bus(10'h201, 0, 0, 0, 1); check("R4 read", {sel_a_n, sel_b_n}, 2'b01);
    bus(10'h201, 0, 0, 1, 0); check("R4 write", {sel_a_n, sel_b_n}, 2'b01);
    bus(10'h201, 0, 0, 1, 1); check("R4 idle", {sel_a_n, sel_b_n}, 2'b11);
    for (int i = 0; i < 10; i++) begin
      bus(10'h201 ^ (10'h1 << i), 0, 0, 0, 0);
      check("R1 neighbour miss", {sel_a_n, sel_b_n}, 2'b11);
    end
    bus(10'h201, 1, 0, 0, 0); check("R2 aen blocks", {sel_a_n, sel_b_n}, 2'b11);
    bus(10'h201, 0, 1, 0, 0); check("R3 upper blocks", {sel_a_n, sel_b_n}, 2'b11);
  endtask

  task automatic t_split();
    do_reset(1'b0);
    check("R7 mode latched split", {1'b0, mode_o}, 2'b00);
    bus(10'h201, 0, 0, 0, 1); check("R5 read", {sel_a_n, sel_b_n}, 2'b01);
    bus(10'h201, 0, 0, 1, 0); check("R6 write", {sel_a_n, sel_b_n}, 2'b10);
    bus(10'h201, 0, 0, 0, 0); check("R5 R6 both", {sel_a_n, sel_b_n}, 2'b00);
    bus(10'h200, 0, 0, 0, 0); check("R1 miss split", {sel_a_n, sel_b_n}, 2'b11);
    bus(10'h201, 1, 0, 0, 1); check("R2 aen split", {sel_a_n, sel_b_n}, 2'b11);
    bus(10'h201, 0, 1, 1, 0); check("R3 upper split", {sel_a_n, sel_b_n}, 2'b11);
  endtask

  task automatic t_release();
    bus(10'h201, 0, 0, 0, 1);
    @(posedge clk); #3;
    rd_n = 1'b1; #1;
    check("R9 release same cycle", {sel_a_n, sel_b_n}, 2'b11);
  endtask

  task automatic t_strap_hold();
    @(negedge clk); mode_strap = 1'b1;
    repeat (3) @(posedge clk); #2;
    check("R7 strap ignored after reset", {1'b0, mode_o}, 2'b00);
    bus(10'h201, 0, 0, 1, 0);
    check("R7 still split", {sel_a_n, sel_b_n}, 2'b10);
    bus(10'h201, 0, 0, 1, 1);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_combined();
    t_split();
    t_release();
    t_strap_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule